// File: doc/BRIEF.md
# ROM-Sequenced Accumulator CPU Controller

This block is the control unit of a small accumulator CPU. The machine has 16-bit words and 12-bit addresses. A five-bit state register selects one word of a constant signal table. That word drives every datapath control output for the current cycle. It also says where the sequence goes next. For most states the word names its successor directly. A branching word instead names one of the jump tables. The selected jump table is then indexed either by the instruction opcode (to dispatch after decode) or by the skip code together with the accumulator sign and zero flags (to choose between the skip and fall-through paths of a conditional skip).

Each instruction begins with the same two fetch states and one decode state. The datapath places IR's address field on MAR in the decode state, and the last state of every instruction returns to the first fetch state. The outputs are decoded straight from the registered state. A surrounding datapath therefore sees stable control codes for the whole cycle.

Top module: `rom_seq_ctrl`

## Requirements
- R1: Output encodings. `bus_src`: 0 none, 1 memory, 2 PC, 3 MBR, 4 AC, 5 input register, 6 IR address field. `bus_dst`: 0 none, 1 memory, 2 MAR, 3 MBR, 4 AC, 5 output register, 6 IR, 7 PC. `ac_sel`: 0 bus, 1 ALU, 2 MBR, 3 constant one. `alu_op`: 0 pass, 1 add, 2 subtract, 3 zero. Fields not named for a cycle are 0. While `rst` is high, and in the first cycle after it falls, the controller shows fetch step one: PC to MAR, with `halted` low.
- R2: Fetch runs as three cycles: PC→MAR; memory→IR with `pc_inc`=1; IR address field→MAR (decode). The cycle after decode is the first execute cycle of the opcode presented.
- R3: Load (opcode 1) executes memory→MBR, then AC←MBR (`bus_dst`=4, `ac_sel`=2), and then returns to fetch.
- R4: Store (opcode 2) executes AC→MBR, then MBR→memory, and then returns to fetch.
- R5: Add (opcode 3) and Subt (opcode 4) execute memory→MBR, then AC←ALU (`ac_sel`=1) with `alu_op` 1 or 2 respectively, and then return to fetch.
- R6: Skipcond (opcode 8) spends one idle evaluation cycle. The skip is taken when the skip code is 0 and AC is negative, when it is 1 and AC is zero, or when it is 2 and AC is neither negative nor zero. Skip code 3 never skips. A taken skip adds one cycle with only `pc_inc`=1 before fetch; a skip that is not taken goes straight to fetch.
- R7: JumpI (opcode 12) executes memory→MBR, then MBR→PC.
- R8: Halt (opcode 7) enters a state that holds `halted`=1 with all other outputs 0, whatever the inputs do, until reset.
- R9: `opcode` is used only in the decode cycle. A change to it during an execute sequence does not alter that sequence.
- R10: AddI (11), LoadI (13) and StoreI (14) first execute memory→MBR and then MBR→MAR. They then follow the direct sequences: memory→MBR then AC←ALU add; memory→MBR then AC←MBR; AC→MBR then MBR→memory.
- R11: JnS (opcode 0) executes PC→MBR, MBR→memory, IR address field→MBR, AC←one (`ac_sel`=3), AC←ALU add, and AC→PC.
- R12: Jump (9) executes IR address field→PC. Input (5) executes input register→AC with `ac_sel`=0. Output (6) executes AC→output register. Clear (10) executes AC←ALU with `alu_op`=3. Each of these takes one cycle.
- R13: Opcode 15 has no execute cycle: decode is followed directly by fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode bits of IR |
| skip_code | input | 2 | Condition field of IR used by Skipcond |
| ac_neg | input | 1 | Accumulator is negative |
| ac_zero | input | 1 | Accumulator is zero |
| bus_src | output | 3 | Device driving the bus |
| bus_dst | output | 3 | Device loading from the bus |
| ac_sel | output | 2 | Accumulator input select |
| alu_op | output | 2 | ALU operation |
| pc_inc | output | 1 | Increment PC this cycle |
| halted | output | 1 | Machine stopped |

## Verification
A wrong entry in the signal table shows on the ports in the same cycle that the state is occupied, as a wrong source, destination or select code. A wrong successor or jump-table entry first shows one cycle later, as an unexpected transfer pair. For that reason every instruction is followed step by step from fetch back to fetch, and each cycle's full output vector is compared. Skipcond is run for every skip code against all three flag situations, so that a misplaced jump-table index appears as an extra or missing increment cycle.

// File: rtl/rom_seq_ctrl.sv
module rom_seq_ctrl #(
  parameter int STATE_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  input  logic [1:0] skip_code,
  input  logic       ac_neg,
  input  logic       ac_zero,
  output logic [2:0] bus_src,
  output logic [2:0] bus_dst,
  output logic [1:0] ac_sel,
  output logic [1:0] alu_op,
  output logic       pc_inc,
  output logic       halted
);
  localparam int NSTATE = 1 << STATE_W;
  localparam int JADDR_W = 6;
  localparam int NJUMP = 1 << JADDR_W;

  localparam logic [2:0] S_NO = 3'd0, S_MEM = 3'd1, S_PC = 3'd2, S_MBR = 3'd3,
                         S_AC = 3'd4, S_IN = 3'd5, S_IR = 3'd6;
  localparam logic [2:0] D_NO = 3'd0, D_MEM = 3'd1, D_MAR = 3'd2, D_MBR = 3'd3,
                         D_AC = 3'd4, D_OUT = 3'd5, D_IR = 3'd6, D_PC = 3'd7;
  localparam logic [1:0] A_BUS = 2'd0, A_ALU = 2'd1, A_MBR = 2'd2, A_ONE = 2'd3;
  localparam logic [1:0] OP_PASS = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_ZERO = 2'd3;

  localparam logic [STATE_W-1:0]
    ST_F0 = 0, ST_F1 = 1, ST_DEC = 2,
    ST_LD0 = 3, ST_LD1 = 4, ST_ST0 = 5, ST_ST1 = 6,
    ST_AD0 = 7, ST_AD1 = 8, ST_SB0 = 9, ST_SB1 = 10,
    ST_IN = 11, ST_OUT = 12, ST_HLT = 13, ST_SKC = 14, ST_SKP = 15,
    ST_JMP = 16, ST_CLR = 17, ST_AI0 = 18, ST_AI1 = 19,
    ST_LI0 = 20, ST_LI1 = 21, ST_JI0 = 22, ST_JI1 = 23,
    ST_SI0 = 24, ST_SI1 = 25, ST_JS0 = 26, ST_JS1 = 27,
    ST_JS2 = 28, ST_JS3 = 29, ST_JS4 = 30, ST_JS5 = 31;

  typedef struct packed {
    logic               hlt;
    logic               inc;
    logic [1:0]         alu;
    logic [1:0]         acs;
    logic [2:0]         dst;
    logic [2:0]         src;
    logic               brn;
    logic [1:0]         tsel;
    logic [STATE_W-1:0] nxt;
  } cw_t;

  function automatic cw_t mv(input logic [2:0] s, input logic [2:0] d,
                             input logic [STATE_W-1:0] n);
    cw_t w = '0;
    w.src = s; w.dst = d; w.nxt = n;
    return w;
  endfunction

  function automatic cw_t acw(input logic [2:0] s, input logic [1:0] a,
                              input logic [1:0] op, input logic [STATE_W-1:0] n);
    cw_t w = mv(s, D_AC, n);
    w.acs = a; w.alu = op;
    return w;
  endfunction

  function automatic cw_t sig_entry(input int s);
    cw_t w = '0;
    case (s)
      0:  w = mv(S_PC, D_MAR, ST_F1);
      1:  begin w = mv(S_MEM, D_IR, ST_DEC); w.inc = 1'b1; end
      2:  begin w = mv(S_IR, D_MAR, ST_F0); w.brn = 1'b1; w.tsel = 2'd0; end
      3:  w = mv(S_MEM, D_MBR, ST_LD1);
      4:  w = acw(S_NO, A_MBR, OP_PASS, ST_F0);
      5:  w = mv(S_AC, D_MBR, ST_ST1);
      6:  w = mv(S_MBR, D_MEM, ST_F0);
      7:  w = mv(S_MEM, D_MBR, ST_AD1);
      8:  w = acw(S_NO, A_ALU, OP_ADD, ST_F0);
      9:  w = mv(S_MEM, D_MBR, ST_SB1);
      10: w = acw(S_NO, A_ALU, OP_SUB, ST_F0);
      11: w = acw(S_IN, A_BUS, OP_PASS, ST_F0);
      12: w = mv(S_AC, D_OUT, ST_F0);
      13: begin w = mv(S_NO, D_NO, ST_HLT); w.hlt = 1'b1; end
      14: begin w = mv(S_NO, D_NO, ST_F0); w.brn = 1'b1; w.tsel = 2'd1; end
      15: begin w = mv(S_NO, D_NO, ST_F0); w.inc = 1'b1; end
      16: w = mv(S_IR, D_PC, ST_F0);
      17: w = acw(S_NO, A_ALU, OP_ZERO, ST_F0);
      18: w = mv(S_MEM, D_MBR, ST_AI1);
      19: w = mv(S_MBR, D_MAR, ST_AD0);
      20: w = mv(S_MEM, D_MBR, ST_LI1);
      21: w = mv(S_MBR, D_MAR, ST_LD0);
      22: w = mv(S_MEM, D_MBR, ST_JI1);
      23: w = mv(S_MBR, D_PC, ST_F0);
      24: w = mv(S_MEM, D_MBR, ST_SI1);
      25: w = mv(S_MBR, D_MAR, ST_ST0);
      26: w = mv(S_PC, D_MBR, ST_JS1);
      27: w = mv(S_MBR, D_MEM, ST_JS2);
      28: w = mv(S_IR, D_MBR, ST_JS3);
      29: w = acw(S_NO, A_ONE, OP_PASS, ST_JS4);
      30: w = acw(S_NO, A_ALU, OP_ADD, ST_JS5);
      31: w = mv(S_AC, D_PC, ST_F0);
      default: w = mv(S_NO, D_NO, ST_F0);
    endcase
    return w;
  endfunction

  function automatic logic [STATE_W-1:0] jump_entry(input int a);
    logic [1:0] t = 2'(a >> 4);
    logic [3:0] i = 4'(a);
    logic take;
    logic [STATE_W-1:0] r = ST_F0;
    if (t == 2'd0) begin
      case (i)
        4'd0:  r = ST_JS0;  4'd1:  r = ST_LD0;  4'd2:  r = ST_ST0;  4'd3:  r = ST_AD0;
        4'd4:  r = ST_SB0;  4'd5:  r = ST_IN;   4'd6:  r = ST_OUT;  4'd7:  r = ST_HLT;
        4'd8:  r = ST_SKC;  4'd9:  r = ST_JMP;  4'd10: r = ST_CLR;  4'd11: r = ST_AI0;
        4'd12: r = ST_JI0;  4'd13: r = ST_LI0;  4'd14: r = ST_SI0;  default: r = ST_F0;
      endcase
    end else if (t == 2'd1) begin
      case (i[3:2])
        2'd0:    take = i[1];
        2'd1:    take = i[0];
        2'd2:    take = !i[1] && !i[0];
        default: take = 1'b0;
      endcase
      r = take ? ST_SKP : ST_F0;
    end
    return r;
  endfunction

  cw_t                sig_rom  [NSTATE];
  logic [STATE_W-1:0] jump_rom [NJUMP];

  for (genvar g = 0; g < NSTATE; g++) begin : g_sig
    assign sig_rom[g] = sig_entry(g);
  end
  for (genvar g = 0; g < NJUMP; g++) begin : g_jmp
    assign jump_rom[g] = jump_entry(g);
  end

  logic [STATE_W-1:0] state;
  cw_t                cur;
  logic [JADDR_W-1:0] jaddr;
  logic [STATE_W-1:0] nxt_state;

  assign cur       = sig_rom[state];
  assign jaddr     = {cur.tsel, (cur.tsel == 2'd0) ? opcode : {skip_code, ac_neg, ac_zero}};
  assign nxt_state = cur.brn ? jump_rom[jaddr] : cur.nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F0;
    else     state <= nxt_state;
  end

  assign bus_src = cur.src;
  assign bus_dst = cur.dst;
  assign ac_sel  = cur.acs;
  assign alu_op  = cur.alu;
  assign pc_inc  = cur.inc;
  assign halted  = cur.hlt;
endmodule

// File: rtl/rom_seq_ctrl_chk.sv
module rom_seq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] bus_src,
  input logic [2:0] bus_dst,
  input logic [1:0] ac_sel,
  input logic [1:0] alu_op,
  input logic       pc_inc,
  input logic       halted
);
  logic fetch0;
  assign fetch0 = (bus_src == 3'd2) && (bus_dst == 3'd2) && !pc_inc && !halted;

  a_r1_reset_fetch: assert property (@(posedge clk) $past(rst) |-> fetch0);

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    fetch0 |=> (bus_src == 3'd1 && bus_dst == 3'd6 && pc_inc));

  a_r2_decode_step: assert property (@(posedge clk) disable iff (rst)
    (bus_src == 3'd1 && bus_dst == 3'd6) |=> (bus_src == 3'd6 && bus_dst == 3'd2 && !pc_inc));

  a_r3_load_returns: assert property (@(posedge clk) disable iff (rst)
    (bus_dst == 3'd4 && ac_sel == 2'd2) |=> fetch0);

  a_r6_skip_returns: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && bus_src == 3'd0 && bus_dst == 3'd0) |=> fetch0);

  a_r8_halt_sticks: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r8_halt_idle: assert property (@(posedge clk) disable iff (rst)
    halted |-> (bus_src == 3'd0 && bus_dst == 3'd0 && !pc_inc && ac_sel == 2'd0 && alu_op == 2'd0));
endmodule

bind rom_seq_ctrl rom_seq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_src(bus_src), .bus_dst(bus_dst),
  .ac_sel(ac_sel), .alu_op(alu_op), .pc_inc(pc_inc), .halted(halted)
);

// File: tb/rom_seq_ctrl_bench.sv
module rom_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] opcode = '0;
  logic [1:0] skip_code = '0;
  logic ac_neg = 1'b0, ac_zero = 1'b0;
  logic [2:0] bus_src, bus_dst;
  logic [1:0] ac_sel, alu_op;
  logic pc_inc, halted;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rom_seq_ctrl u_rom_seq_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .skip_code(skip_code),
    .ac_neg(ac_neg), .ac_zero(ac_zero), .bus_src(bus_src), .bus_dst(bus_dst),
    .ac_sel(ac_sel), .alu_op(alu_op), .pc_inc(pc_inc), .halted(halted)
  );

  task automatic chk(input string tag, input int s, input int d, input int a,
                     input int op, input int inc, input int h);
    logic [11:0] got, exp;
    got = {bus_src, bus_dst, ac_sel, alu_op, pc_inc, halted};
    exp = {3'(s), 3'(d), 2'(a), 2'(op), 1'(inc), 1'(h)};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s src/dst/acs/alu/inc/hlt actual %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
               tag, bus_src, bus_dst, ac_sel, alu_op, pc_inc, halted, s, d, a, op, inc, h);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fetch(input string tag, input int op);
    opcode = 4'(op);
    chk({tag, " R2 fetch0"}, 2, 2, 0, 0, 0, 0); step();
    chk({tag, " R2 fetch1"}, 1, 6, 0, 0, 1, 0); step();
    chk({tag, " R2 decode"}, 6, 2, 0, 0, 0, 0); step();
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk("R1 in reset", 2, 2, 0, 0, 0, 0);
    rst = 1'b0; step();
    chk("R1 after reset", 1, 6, 0, 0, 1, 0);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 first cycle", 2, 2, 0, 0, 0, 0);
  endtask

  task automatic t_load();
    fetch("load", 1);
    opcode = 4'd9;
    chk("R3 mem->mbr", 1, 3, 0, 0, 0, 0); step();
    opcode = 4'd7;
    chk("R3 ac<-mbr R9", 0, 4, 2, 0, 0, 0); step();
  endtask

  task automatic t_store();
    fetch("store", 2);
    chk("R4 ac->mbr", 4, 3, 0, 0, 0, 0); step();
    chk("R4 mbr->mem", 3, 1, 0, 0, 0, 0); step();
  endtask

  task automatic t_arith();
    fetch("add", 3);
    chk("R5 add mem->mbr", 1, 3, 0, 0, 0, 0); step();
    chk("R5 add alu", 0, 4, 1, 1, 0, 0); step();
    fetch("sub", 4);
    chk("R5 sub mem->mbr", 1, 3, 0, 0, 0, 0); step();
    chk("R5 sub alu", 0, 4, 1, 2, 0, 0); step();
  endtask

  task automatic t_skip();
    for (int sk = 0; sk < 4; sk++) begin
      for (int f = 0; f < 3; f++) begin
        bit n, z, take;
        n = (f == 0); z = (f == 1);
        take = (sk == 0) ? n : (sk == 1) ? z : (sk == 2) ? (!n && !z) : 1'b0;
        skip_code = 2'(sk); ac_neg = n; ac_zero = z;
        fetch("skip", 8);
        chk("R6 evaluate", 0, 0, 0, 0, 0, 0); step();
        if (take) begin
          chk("R6 skip taken", 0, 0, 0, 0, 1, 0); step();
        end
        chk("R6 back to fetch", 2, 2, 0, 0, 0, 0);
      end
    end
    ac_neg = 1'b0; ac_zero = 1'b0; skip_code = '0;
  endtask

  task automatic t_jumpi();
    fetch("jumpi", 12);
    chk("R7 mem->mbr", 1, 3, 0, 0, 0, 0); step();
    chk("R7 mbr->pc", 3, 7, 0, 0, 0, 0); step();
  endtask

  task automatic t_indirect();
    fetch("addi", 11);
    chk("R10 addi ptr", 1, 3, 0, 0, 0, 0); step();
    chk("R10 addi mar", 3, 2, 0, 0, 0, 0); step();
    chk("R10 addi data", 1, 3, 0, 0, 0, 0); step();
    chk("R10 addi alu", 0, 4, 1, 1, 0, 0); step();
    fetch("loadi", 13);
    chk("R10 loadi ptr", 1, 3, 0, 0, 0, 0); step();
    chk("R10 loadi mar", 3, 2, 0, 0, 0, 0); step();
    chk("R10 loadi data", 1, 3, 0, 0, 0, 0); step();
    chk("R10 loadi ac", 0, 4, 2, 0, 0, 0); step();
    fetch("storei", 14);
    chk("R10 storei ptr", 1, 3, 0, 0, 0, 0); step();
    chk("R10 storei mar", 3, 2, 0, 0, 0, 0); step();
    chk("R10 storei ac", 4, 3, 0, 0, 0, 0); step();
    chk("R10 storei mem", 3, 1, 0, 0, 0, 0); step();
  endtask

  task automatic t_jns();
    fetch("jns", 0);
    chk("R11 pc->mbr", 2, 3, 0, 0, 0, 0); step();
    chk("R11 mbr->mem", 3, 1, 0, 0, 0, 0); step();
    chk("R11 ir->mbr", 6, 3, 0, 0, 0, 0); step();
    chk("R11 ac<-one", 0, 4, 3, 0, 0, 0); step();
    chk("R11 ac add", 0, 4, 1, 1, 0, 0); step();
    chk("R11 ac->pc", 4, 7, 0, 0, 0, 0); step();
  endtask

  task automatic t_single();
    fetch("jump", 9);   chk("R12 jump", 6, 7, 0, 0, 0, 0); step();
    fetch("input", 5);  chk("R12 input", 5, 4, 0, 0, 0, 0); step();
    fetch("output", 6); chk("R12 output", 4, 5, 0, 0, 0, 0); step();
    fetch("clear", 10); chk("R12 clear", 0, 4, 1, 3, 0, 0); step();
  endtask

  task automatic t_undef();
    fetch("undef", 15);
    chk("R13 straight to fetch", 2, 2, 0, 0, 0, 0);
  endtask

  task automatic t_halt();
    fetch("halt", 7);
    for (int k = 0; k < 4; k++) begin
      opcode = 4'(k); ac_neg = k[0]; skip_code = 2'(k);
      chk("R8 halted", 0, 0, 0, 0, 0, 1); step();
    end
    rst = 1'b1; step(); rst = 1'b0;
    chk("R8 reset leaves halt", 2, 2, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_load();
    t_store();
    t_arith();
    t_skip();
    t_jumpi();
    t_indirect();
    t_jns();
    t_single();
    t_undef();
    t_halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule